// File: doc/BRIEF.md
# Quad DAC Serial Register Front-End

This block is the digital front end of a four-channel 12-bit converter. A host shifts 16-bit words in on one data pin. A serial clock times each bit, and an active-low chip select frames the word. Each word names one of four channels and carries a 12-bit straight-binary code: 000h gives the lowest output and FFFh the highest. When chip select rises, the word is frozen. While the load input is low, the frozen code flows into the named channel's holding register. The four holding registers drive the analog converters in parallel.

The serial clock, chip select, data and load inputs are treated as slow asynchronous pins. They are brought into the system clock domain through two-flop synchronisers, and the serial clock's rising edge is found by edge detection. The transparent latch behaviour of the load input is built as a synchronous register that is written on every system clock cycle while load is low.

An active-low preset pin forces all four holding registers at once, without waiting for a clock, to either zero-scale or mid-scale. A select pin picks which of the two. The synchronous system reset `rst` loads the same preset code.

Top module: `qdac_front`

## Requirements
- R1: Four independent 12-bit outputs (`code_a` to `code_d`) each keep their value until a write addressed to them, a preset or a reset.
- R2: A word is 16 bits, sampled MSB first on each rising edge of `sclk` while `cs_n` is low. Bits [15:14] select the channel (00=A, 01=B, 10=C, 11=D) and bits [11:0] are the code.
- R3: A code written to a channel appears on that channel's output bit for bit, across the whole range 000h to FFFh.
- R4: A write changes only the addressed channel's output. The other three outputs keep their values.
- R5: While `load_n` is high, no output changes. Once `load_n` goes low, the addressed output takes the frozen code within 8 system clocks.
- R6: While `preset_n` is low, every output reads 000h if `preset_mid` is 0 and 800h if `preset_mid` is 1. This takes effect without any `clk` edge and whatever the level of `load_n`.
- R7: Rising `sclk` edges seen while `cs_n` is high do not shift any bit into the word.
- R8: The channel and code are frozen when `cs_n` rises. A transfer that is still in progress changes no output, even while `load_n` is held low.
- R9: Bits [13:12] of the word have no effect on any output.
- R10: After `preset_n` is released, or after `rst`, no output changes until a complete word has been closed by a rising `cs_n`. `rst` loads every output with the code chosen by `preset_mid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial bit clock, asynchronous to `clk` |
| cs_n | input | 1 | Active-low word framing select |
| sdin | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low load; holding register follows the frozen word while low |
| preset_n | input | 1 | Asynchronous active-low preset of all holding registers |
| preset_mid | input | 1 | Preset code select: 0 gives 000h, 1 gives 800h |
| code_a | output | 12 | Channel A code |
| code_b | output | 12 | Channel B code |
| code_c | output | 12 | Channel C code |
| code_d | output | 12 | Channel D code |

## Verification
Several rules are checked by the assertions on every cycle:
- the preset value while `preset_n` is low;
- no holding register moving while the synchronised load is high;
- never more than one channel changing in a cycle;
- a shift register that stays still while chip select is high;
- a frozen word that changes only on the chip select rise.

Other behaviour only the bench's directed scenarios can show, because it depends on the content of whole serial words:
- the bit order of the word;
- that the pad bits are ignored;
- that clocks seen while chip select is high are dropped in the middle of a split transfer;
- that outputs stay at the preset value after release until a fresh word arrives.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int CODE_W   = 12;
    localparam int NUM_CH   = 4;
    localparam int ADDR_W   = $clog2(NUM_CH);
    localparam int PAD_W    = 2;
    localparam int FRAME_W  = ADDR_W + PAD_W + CODE_W;
    localparam int SYNC_LEN = 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [ADDR_W-1:0] {
        CH_A = 2'd0,
        CH_B = 2'd1,
        CH_C = 2'd2,
        CH_D = 2'd3
    } chan_e;

    // MSB-first word layout: channel, don't-care pad, code
    typedef struct packed {
        chan_e              chan;
        logic [PAD_W-1:0]   pad;
        code_t              code;
    } frame_t;

    // pin-level inputs after synchronisation
    typedef struct packed {
        logic sclk;
        logic cs_n;
        logic sdin;
        logic load_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1, sdin: 1'b0, load_n: 1'b1};

    function automatic code_t preset_code(input logic mid);
        code_t c;
        c = '0;
        if (mid) c[CODE_W-1] = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int STAGES           = 2,
    parameter int WIDTH            = 1,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter
    import qdac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  preset_n,
    input  logic  sclk_s,
    input  logic  cs_n_s,
    input  logic  sdin_s,
    output chan_e word_chan,
    output code_t word_code,
    output logic  armed
);
    logic   sclk_q;
    logic   cs_q;
    logic   bit_strobe;
    logic   close_word;
    frame_t shift_q;
    chan_e  chan_q;
    code_t  code_q;

    assign bit_strobe = sclk_s & ~sclk_q & ~cs_n_s;
    assign close_word = cs_n_s & ~cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            cs_q    <= 1'b1;
            shift_q <= '0;
            chan_q  <= CH_A;
            code_q  <= '0;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_n_s;
            if (bit_strobe)
                shift_q <= frame_t'({shift_q[FRAME_W-2:0], sdin_s});
            if (close_word) begin
                chan_q <= shift_q.chan;
                code_q <= shift_q.code;
            end
        end
    end

    // a stale word must not be replayed after a preset
    always_ff @(posedge clk or negedge preset_n) begin
        if (!preset_n)       armed <= 1'b0;
        else if (rst)        armed <= 1'b0;
        else if (close_word) armed <= 1'b1;
    end

    assign word_chan = chan_q;
    assign word_code = code_q;

    // R7: select high freezes the shift register
    a_r7_idle_no_shift: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> $stable(shift_q));

    // R8: frozen word only moves on the select rise
    a_r8_word_frozen: assert property (@(posedge clk) disable iff (rst)
        !close_word |=> ($stable(chan_q) && $stable(code_q)));

    // R2: a closed word arms the load path
    a_r2_close_arms: assert property (@(posedge clk) disable iff (rst || !preset_n)
        close_word |=> armed);
endmodule

// File: rtl/qdac_hold_bank.sv
module qdac_hold_bank
    import qdac_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       preset_n,
    input  logic                       preset_mid,
    input  logic                       load_n_s,
    input  logic                       armed,
    input  chan_e                      word_chan,
    input  code_t                      word_code,
    output logic [NUM_CH*CODE_W-1:0]   codes
);
    logic [NUM_CH-1:0] wr_en;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        code_t hold_q;

        assign wr_en[g] = armed & ~load_n_s & (word_chan == chan_e'(g));

        always_ff @(posedge clk or negedge preset_n) begin
            if (!preset_n)     hold_q <= preset_code(preset_mid);
            else if (rst)      hold_q <= preset_code(preset_mid);
            else if (wr_en[g]) hold_q <= word_code;
        end

        assign codes[g*CODE_W +: CODE_W] = hold_q;
    end

    // checking support: previous output snapshot
    logic [NUM_CH*CODE_W-1:0] codes_prev;
    logic [NUM_CH-1:0]        moved;

    always_ff @(posedge clk) codes_prev <= codes;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_mv
        assign moved[g] = codes[g*CODE_W +: CODE_W] != codes_prev[g*CODE_W +: CODE_W];
    end

    // R6: preset level on every channel
    a_r6_preset_level: assert property (@(posedge clk) disable iff (rst)
        (!preset_n && $stable(preset_mid)) |->
            (codes == {NUM_CH{preset_code(preset_mid)}}));

    // R5: load high blocks all writes
    a_r5_load_high_hold: assert property (@(posedge clk) disable iff (rst || !preset_n)
        load_n_s |=> $stable(codes));

    // R4: never more than one channel moves per cycle
    a_r4_single_channel: assert property (@(posedge clk) disable iff (rst || !preset_n)
        (!$past(rst) && $past(preset_n)) |-> ($countones(moved) <= 1));
endmodule

// File: rtl/qdac_front.sv
module qdac_front
    import qdac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        sdin,
    input  logic        load_n,
    input  logic        preset_n,
    input  logic        preset_mid,
    output logic [11:0] code_a,
    output logic [11:0] code_b,
    output logic [11:0] code_c,
    output logic [11:0] code_d
);
    pins_t pins_raw;
    pins_t pins_s;
    chan_e word_chan;
    code_t word_code;
    logic  armed;
    logic [NUM_CH*CODE_W-1:0] codes;

    assign pins_raw = '{sclk: sclk, cs_n: cs_n, sdin: sdin, load_n: load_n};

    qdac_sync #(
        .STAGES (SYNC_LEN),
        .WIDTH  ($bits(pins_t)),
        .INIT   (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    qdac_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .preset_n  (preset_n),
        .sclk_s    (pins_s.sclk),
        .cs_n_s    (pins_s.cs_n),
        .sdin_s    (pins_s.sdin),
        .word_chan (word_chan),
        .word_code (word_code),
        .armed     (armed)
    );

    qdac_hold_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .preset_n   (preset_n),
        .preset_mid (preset_mid),
        .load_n_s   (pins_s.load_n),
        .armed      (armed),
        .word_chan  (word_chan),
        .word_code  (word_code),
        .codes      (codes)
    );

    assign code_a = codes[0*CODE_W +: CODE_W];
    assign code_b = codes[1*CODE_W +: CODE_W];
    assign code_c = codes[2*CODE_W +: CODE_W];
    assign code_d = codes[3*CODE_W +: CODE_W];
endmodule

// File: tb/qdac_front_tb.sv
module qdac_front_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdin = 1'b0;
    logic load_n = 1'b1;
    logic preset_n = 1'b1;
    logic preset_mid = 1'b0;
    logic [11:0] code_a, code_b, code_c, code_d;

    logic [11:0] exp_q [4];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdac_front u_dut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdin(sdin),
        .load_n(load_n), .preset_n(preset_n), .preset_mid(preset_mid),
        .code_a(code_a), .code_b(code_b), .code_c(code_c), .code_d(code_d)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [11:0] out_of(input int ch);
        case (ch)
            0: return code_a;
            1: return code_b;
            2: return code_c;
            default: return code_d;
        endcase
    endfunction

    task automatic chk(input string req, input int ch, input logic [11:0] got, input logic [11:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s ch%0d got %03h expected %03h", req, ch, got, exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int c = 0; c < 4; c++) chk(req, c, out_of(c), exp_q[c]);
    endtask

    task automatic shift_bits(input logic [15:0] w, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            sdin = w[i];
            tick(HALF_BIT);
            sclk = 1'b1;
            tick(HALF_BIT);
            sclk = 1'b0;
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        cs_n = 1'b0;
        tick(HALF_BIT);
        shift_bits(w, 15, 0);
        tick(HALF_BIT);
        cs_n = 1'b1;
        tick(10);
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        tick(8);
        load_n = 1'b1;
        tick(6);
    endtask

    function automatic logic [15:0] mk(input int ch, input logic [1:0] pad, input logic [11:0] v);
        return {2'(ch), pad, v};
    endfunction

    // R10: system reset loads the selected preset code
    task automatic t_reset();
        tick(2);
        for (int c = 0; c < 4; c++) exp_q[c] = 12'h000;
        chk_all("R10_rst_zero");
        preset_mid = 1'b1;
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(2);
        for (int c = 0; c < 4; c++) exp_q[c] = 12'h800;
        chk_all("R10_rst_mid");
    endtask

    // R1 R2 R3 R4: one word per channel, only the addressed one moves
    task automatic t_channels();
        logic [11:0] vals [4];
        vals[0] = 12'h123; vals[1] = 12'hFFF; vals[2] = 12'h000; vals[3] = 12'hA5C;
        for (int c = 0; c < 4; c++) begin
            send_word(mk(c, 2'b00, vals[c]));
            pulse_load();
            exp_q[c] = vals[c];
            chk_all("R4_only_addressed");
        end
        chk("R3_full_scale", 1, code_b, 12'hFFF);
        chk("R1_retain", 0, code_a, 12'h123);
    endtask

    // R5: load high blocks the write, load low applies it
    task automatic t_load_high();
        send_word(mk(1, 2'b00, 12'h6E1));
        tick(20);
        chk_all("R5_load_high_no_change");
        pulse_load();
        exp_q[1] = 12'h6E1;
        chk_all("R5_load_applies");
    endtask

    // R9: pad bits ignored
    task automatic t_pad();
        send_word(mk(2, 2'b11, 12'h5A5));
        pulse_load();
        exp_q[2] = 12'h5A5;
        chk_all("R9_pad_ignored");
    endtask

    // R7: split transfer with sclk pulses while select is high
    task automatic t_cs_high();
        logic [15:0] w;
        w = mk(3, 2'b00, 12'h3C7);
        cs_n = 1'b0;
        tick(HALF_BIT);
        shift_bits(w, 15, 4);
        tick(HALF_BIT);
        cs_n = 1'b1;
        tick(HALF_BIT);
        shift_bits(16'hFFFF, 3, 0);
        tick(HALF_BIT);
        cs_n = 1'b0;
        tick(HALF_BIT);
        shift_bits(w, 3, 0);
        tick(HALF_BIT);
        cs_n = 1'b1;
        tick(10);
        pulse_load();
        exp_q[3] = 12'h3C7;
        chk_all("R7_idle_clocks_dropped");
    endtask

    // R8: transfer in progress does not disturb a transparent register
    task automatic t_frozen();
        logic [15:0] w;
        load_n = 1'b0;
        send_word(mk(0, 2'b00, 12'h321));
        exp_q[0] = 12'h321;
        chk_all("R8_transparent_write");
        w = mk(1, 2'b00, 12'h777);
        cs_n = 1'b0;
        tick(HALF_BIT);
        shift_bits(w, 15, 6);
        tick(6);
        chk_all("R8_mid_transfer");
        shift_bits(w, 5, 0);
        tick(HALF_BIT);
        cs_n = 1'b1;
        tick(10);
        exp_q[1] = 12'h777;
        chk_all("R8_after_close");
        load_n = 1'b1;
        tick(4);
    endtask

    // R6 R10: asynchronous preset, both codes, no replay afterwards
    task automatic t_preset();
        preset_mid = 1'b1;
        @(negedge clk);
        preset_n = 1'b0;
        #1;
        for (int c = 0; c < 4; c++) exp_q[c] = 12'h800;
        chk_all("R6_async_mid");
        load_n = 1'b0;
        tick(4);
        chk_all("R6_mid_load_low");
        preset_n = 1'b1;
        tick(20);
        chk_all("R10_no_replay");
        preset_mid = 1'b0;
        @(negedge clk);
        preset_n = 1'b0;
        #1;
        for (int c = 0; c < 4; c++) exp_q[c] = 12'h000;
        chk_all("R6_async_zero");
        tick(3);
        preset_n = 1'b1;
        tick(20);
        chk_all("R10_no_replay_zero");
        send_word(mk(3, 2'b00, 12'hFFF));
        exp_q[3] = 12'hFFF;
        chk_all("R3_after_preset");
        load_n = 1'b1;
        tick(4);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        t_reset();
        t_channels();
        t_load_high();
        t_pad();
        t_cs_high();
        t_frozen();
        t_preset();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule